// File: doc/BRIEF.md
# Display Loopback Capture Sequencer

This block is the control side of a path that copies the finished display output back into memory. Software-side logic issues one of three commands (init, start, done) as a single-cycle pulse. The block keeps track of whether capture is unconfigured, configured and idle, or running. It turns each accepted command into a timed sequence on the capture-path control lines: write pause, input-path enable, memory-interface reset, done-status clear, urgent request and write-to-memory enable.

Init also latches the capture window from a stride and a height. The two waits in the start recipe, a short memory-interface reset pulse and a long settle before writing is re-armed, are counted in cycles of a tick-per-microsecond parameter. A testbench can therefore shrink them without changing the order of the recipe. While a timed sequence runs, the block is busy and refuses every command.

Top module: `capture_loop_ctrl`

## Requirements
- R1: After reset, `state_o` is 0 (unconfigured), `busy` and `cmd_err` are low, every control output is low, and `h_end`, `v_end` and `width_m1` are 0.
- R2: An init accepted while not running and not busy sets `h_end` and `width_m1` to stride-1 and `v_end` to height-1, and sets `state_o` to 1 (idle). The change is visible in the cycle after the command. A repeated init in idle reloads the window.
- R3: An init while `state_o` is 2 (running) raises `cmd_err` for exactly one cycle, in the cycle after the command, and leaves the window and state unchanged.
- R4: A start accepted in idle first raises `busy` and `wr_pause`, drops `in_en`, and holds `mif_rst` high for exactly RST_US*TICKS_PER_US cycles.
- R5: In the cycle after `mif_rst` falls, `wr_pause` drops. The block then waits SETTLE_US*TICKS_PER_US cycles with `busy` high.
- R6: After the settle, `done_clr` pulses for one cycle and `urgent` rises in that same cycle. In the next cycle `wr_mem_en` and `in_en` rise, `state_o` becomes 2 and `busy` falls.
- R7: A start while not idle (unconfigured or running) raises `cmd_err` for one cycle and changes no other output.
- R8: A done accepted while not busy sets `state_o` to 1 at once, raises `wr_pause`, drops `in_en`, and pulses `mif_rst` for RST_US*TICKS_PER_US cycles with `busy` high. `urgent` and `wr_mem_en` keep their values.
- R9: Any command while `busy` is high raises `cmd_err` for one cycle and has no effect on state, window or controls.
- R10: Two or more command pulses in the same cycle raise `cmd_err` for one cycle, and none of them takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_init | input | 1 | Init command pulse |
| cmd_start | input | 1 | Start command pulse |
| cmd_done | input | 1 | Done command pulse |
| stride | input | DIM_W | Line length in pixels, taken on init |
| height | input | DIM_W | Frame height in lines, taken on init |
| state_o | output | 2 | 0 unconfigured, 1 idle, 2 running |
| busy | output | 1 | A timed sequence is in progress |
| cmd_err | output | 1 | One-cycle pulse when a command is refused |
| wr_pause | output | 1 | Pause writing to memory |
| in_en | output | 1 | Capture input path enable |
| mif_rst | output | 1 | Memory-interface reset |
| done_clr | output | 1 | One-cycle done-status clear |
| urgent | output | 1 | Urgent write request |
| wr_mem_en | output | 1 | Write-to-memory enable |
| h_end | output | DIM_W | Horizontal window end (start is 0) |
| v_end | output | DIM_W | Vertical window end (start is 0) |
| width_m1 | output | DIM_W | Input interface width minus one |

## Verification
The assertions assume that commands are single-cycle pulses sampled on the rising edge. They also assume that stride and height are stable in the cycle an init is sampled. The stimulus drives every command on the falling edge and holds it for exactly one cycle. It issues commands in all three states, during a busy sequence, and in pairs in one cycle, so the rejection paths are reached on purpose and not by accident.

// File: rtl/capture_loop_ctrl.sv
module capture_loop_ctrl #(
  parameter int DIM_W        = 13,
  parameter int TICKS_PER_US = 100,
  parameter int RST_US       = 10,
  parameter int SETTLE_US    = 20000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_init,
  input  logic             cmd_start,
  input  logic             cmd_done,
  input  logic [DIM_W-1:0] stride,
  input  logic [DIM_W-1:0] height,
  output logic [1:0]       state_o,
  output logic             busy,
  output logic             cmd_err,
  output logic             wr_pause,
  output logic             in_en,
  output logic             mif_rst,
  output logic             done_clr,
  output logic             urgent,
  output logic             wr_mem_en,
  output logic [DIM_W-1:0] h_end,
  output logic [DIM_W-1:0] v_end,
  output logic [DIM_W-1:0] width_m1
);
  localparam int RST_CYC = RST_US * TICKS_PER_US;
  localparam int SET_CYC = SETTLE_US * TICKS_PER_US;
  localparam int MAX_CYC = (SET_CYC > RST_CYC) ? SET_CYC : RST_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1) + 1;

  typedef enum logic [1:0] {ST_UNCFG = 2'd0, ST_IDLE = 2'd1, ST_RUN = 2'd2} cap_st_e;
  typedef enum logic [2:0] {PH_NONE, PH_S_RST, PH_SETTLE, PH_ARM, PH_D_RST} phase_e;

  cap_st_e          st;
  phase_e           ph;
  logic [CNT_W-1:0] cnt;

  wire multi    = $countones({cmd_init, cmd_start, cmd_done}) > 1;
  wire any_cmd  = cmd_init | cmd_start | cmd_done;
  wire ok_init  = cmd_init  && !multi && !busy && st != ST_RUN;
  wire ok_start = cmd_start && !multi && !busy && st == ST_IDLE;
  wire ok_done  = cmd_done  && !multi && !busy;
  wire refuse   = any_cmd && !(ok_init || ok_start || ok_done);
  wire rst_last = cnt == CNT_W'(RST_CYC - 1);
  wire set_last = cnt == CNT_W'(SET_CYC - 1);

  assign busy    = ph != PH_NONE;
  assign state_o = st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_UNCFG;  ph <= PH_NONE;  cnt <= '0;
      cmd_err <= 1'b0; wr_pause <= 1'b0; in_en <= 1'b0; mif_rst <= 1'b0;
      done_clr <= 1'b0; urgent <= 1'b0; wr_mem_en <= 1'b0;
      h_end <= '0; v_end <= '0; width_m1 <= '0;
    end else begin
      cmd_err  <= refuse;
      done_clr <= 1'b0;
      case (ph)
        PH_S_RST:
          if (rst_last) begin
            ph <= PH_SETTLE; cnt <= '0; mif_rst <= 1'b0; wr_pause <= 1'b0;
          end else cnt <= cnt + 1'b1;
        PH_SETTLE:
          if (set_last) begin
            ph <= PH_ARM; done_clr <= 1'b1; urgent <= 1'b1;
          end else cnt <= cnt + 1'b1;
        PH_ARM: begin
          ph <= PH_NONE; wr_mem_en <= 1'b1; in_en <= 1'b1; st <= ST_RUN;
        end
        PH_D_RST:
          if (rst_last) begin
            ph <= PH_NONE; mif_rst <= 1'b0;
          end else cnt <= cnt + 1'b1;
        default: ;
      endcase
      if (ok_init) begin
        h_end <= stride - 1'b1; width_m1 <= stride - 1'b1;
        v_end <= height - 1'b1; st <= ST_IDLE;
      end
      if (ok_start) begin
        ph <= PH_S_RST; cnt <= '0; wr_pause <= 1'b1; in_en <= 1'b0; mif_rst <= 1'b1;
      end
      if (ok_done) begin
        ph <= PH_D_RST; cnt <= '0; st <= ST_IDLE;
        wr_pause <= 1'b1; in_en <= 1'b0; mif_rst <= 1'b1;
      end
    end
  end

  // R4
  mif_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mif_rst |-> wr_pause && !in_en && busy);

  // R6
  run_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2 && $past(state_o) != 2'd2) |-> wr_mem_en && in_en && urgent && !busy);

  // R6
  clr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_clr |=> !done_clr && state_o == 2'd2);

  // R3
  refuse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_err && !$past(busy)) |-> state_o == $past(state_o) && h_end == $past(h_end));

  // R2
  window_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_end != $past(h_end) || v_end != $past(v_end)) |-> $past(cmd_init) && !cmd_err);

  // R9
  busy_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (cmd_init || cmd_start || cmd_done)) |=> cmd_err);
endmodule

// File: tb/test_capture_loop_ctrl.sv
module test_capture_loop_ctrl;
  localparam int DW = 13, TK = 2, RU = 10, SU = 30;
  localparam int RC = RU * TK, SC = SU * TK;

  logic clk = 0, rst_n = 0;
  logic cmd_init = 0, cmd_start = 0, cmd_done = 0;
  logic [DW-1:0] stride = 0, height = 0;
  logic [1:0] state_o;
  logic busy, cmd_err, wr_pause, in_en, mif_rst, done_clr, urgent, wr_mem_en;
  logic [DW-1:0] h_end, v_end, width_m1;

  capture_loop_ctrl #(.DIM_W(DW), .TICKS_PER_US(TK), .RST_US(RU), .SETTLE_US(SU)) i_capture_loop_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_init(cmd_init), .cmd_start(cmd_start), .cmd_done(cmd_done),
    .stride(stride), .height(height), .state_o(state_o), .busy(busy), .cmd_err(cmd_err),
    .wr_pause(wr_pause), .in_en(in_en), .mif_rst(mif_rst), .done_clr(done_clr), .urgent(urgent),
    .wr_mem_en(wr_mem_en), .h_end(h_end), .v_end(v_end), .width_m1(width_m1));

  always #10 clk = ~clk;

  int cyc = 0, checks = 0, fails = 0;
  always @(posedge clk) cyc <= cyc + 1;

  localparam int VW = 2 + 8 + 3 * DW;
  typedef struct { int at; logic [VW-1:0] v; string req; } exp_t;
  exp_t q[$];

  logic [1:0] e_st = 0;
  logic e_pause = 0, e_in = 0, e_urg = 0, e_wen = 0;
  logic [DW-1:0] e_h = 0, e_v = 0, e_w = 0;

  function automatic void snap(int at, logic b, logic er, logic mif, logic clr, string req);
    exp_t e;
    int i;
    e.at = at; e.req = req;
    e.v = {e_st, b, er, e_pause, e_in, mif, clr, e_urg, e_wen, e_h, e_v, e_w};
    i = 0;
    while (i < q.size() && q[i].at <= at) i++;
    q.insert(i, e);
  endfunction

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at == cyc) begin
      logic [VW-1:0] act;
      act = {state_o, busy, cmd_err, wr_pause, in_en, mif_rst, done_clr, urgent, wr_mem_en,
             h_end, v_end, width_m1};
      checks++;
      if (act !== q[0].v) begin
        fails++;
        $display("FAIL %s cycle %0d: actual %h expected %h", q[0].req, cyc, act, q[0].v);
      end
      void'(q.pop_front());
    end
  end

  task automatic wait_to(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic idle_check(string req);
    int n;
    @(negedge clk); n = cyc;
    snap(n + 1, 0, 0, 0, 0, req);
    wait_to(n + 2);
  endtask

  task automatic do_init(int s, int h);
    int n;
    @(negedge clk); n = cyc;
    cmd_init = 1; stride = DW'(s); height = DW'(h);
    if (e_st != 2) begin
      e_h = DW'(s - 1); e_w = DW'(s - 1); e_v = DW'(h - 1); e_st = 1;
      snap(n + 1, 0, 0, 0, 0, "R2");
    end else begin
      snap(n + 1, 0, 1, 0, 0, "R3");
      snap(n + 2, 0, 0, 0, 0, "R3");
    end
    @(negedge clk); cmd_init = 0;
    wait_to(n + 3);
  endtask

  task automatic do_start(bit poke);
    int n;
    @(negedge clk); n = cyc;
    cmd_start = 1;
    if (e_st == 1) begin
      e_pause = 1; e_in = 0;
      snap(n + 1, 1, 0, 1, 0, "R4");
      if (poke) begin
        snap(n + 6, 1, 1, 1, 0, "R9");
        snap(n + 7, 1, 0, 1, 0, "R9");
      end
      snap(n + RC, 1, 0, 1, 0, "R4");
      e_pause = 0;
      snap(n + RC + 1, 1, 0, 0, 0, "R5");
      snap(n + RC + SC, 1, 0, 0, 0, "R5");
      e_urg = 1;
      snap(n + RC + SC + 1, 1, 0, 0, 1, "R6");
      e_wen = 1; e_in = 1; e_st = 2;
      snap(n + RC + SC + 2, 0, 0, 0, 0, "R6");
      @(negedge clk); cmd_start = 0;
      if (poke) begin
        repeat (4) @(negedge clk);
        cmd_init = 1; stride = 13'd99; height = 13'd77;
        @(negedge clk); cmd_init = 0;
      end
      wait_to(n + RC + SC + 3);
    end else begin
      snap(n + 1, 0, 1, 0, 0, "R7");
      snap(n + 2, 0, 0, 0, 0, "R7");
      @(negedge clk); cmd_start = 0;
      wait_to(n + 3);
    end
  endtask

  task automatic do_done();
    int n;
    @(negedge clk); n = cyc;
    cmd_done = 1;
    e_st = 1; e_pause = 1; e_in = 0;
    snap(n + 1, 1, 0, 1, 0, "R8");
    snap(n + RC, 1, 0, 1, 0, "R8");
    snap(n + RC + 1, 0, 0, 0, 0, "R8");
    @(negedge clk); cmd_done = 0;
    wait_to(n + RC + 2);
  endtask

  task automatic do_multi(logic [2:0] b);
    int n;
    @(negedge clk); n = cyc;
    {cmd_init, cmd_start, cmd_done} = b; stride = 13'd5; height = 13'd6;
    snap(n + 1, 0, 1, 0, 0, "R10");
    snap(n + 2, 0, 0, 0, 0, "R10");
    @(negedge clk); {cmd_init, cmd_start, cmd_done} = 3'b000;
    wait_to(n + 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle_check("R1");
    do_start(0);
    do_init(640, 480);
    do_init(800, 600);
    do_start(1);
    do_init(320, 240);
    do_start(0);
    do_multi(3'b011);
    do_done();
    do_multi(3'b101);
    do_start(0);
    do_done();
    do_init(1, 1);
    repeat (4) @(negedge clk);
    if (q.size() != 0) begin
      fails++; checks++;
      $display("FAIL scoreboard: actual %0d pending expected 0", q.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule